// File: doc/BRIEF.md
# Magnitude-Density Automatic Gain Control

This block closes a digital gain loop around a receiver ADC that delivers two bits per channel (sign and magnitude) for an I and a Q path. It counts how many sample strobes carry a set magnitude bit over a window of a fixed number of strobes, 512 by default. When the window closes, it compares each count with a programmed reference and moves a 6-bit PGA gain code by one step toward the target density. The target density is the reference divided by the window length; a reference of 170 gives about one third, which suits a two-bit quantizer. Only the magnitude bits affect the loop, so the sign bits do not enter the block.

A 2-bit mode input sets how the gains are produced. In split mode each channel follows its own count. In locked mode the I count drives a single code that both channels share. In direct mode both codes follow a gain word, with no loop. The fourth code is reserved: the gains freeze, and the windows keep running. A small sequencer with two states, ACCUM and APPLY, times the update. ACCUM moves to APPLY on the cycle after a window closes, and the gain registers load on that transition. APPLY always returns to ACCUM after one cycle, and the done flag is high while in APPLY.

Top module: `mag_agc`

## Requirements
- R1: A synchronous reset clears the window counters and the sequencer and loads both gain codes with 58 (binary 111010). `window_done` is 0 during reset.
- R2: A window closes on its 512th `sample_en` strobe. Only cycles with the strobe count toward the window. `window_done` is high for exactly one cycle, two clock edges after the closing strobe is sampled, and is low at all other times.
- R3: In split or locked mode, a window count below `ref_count` raises the affected gain code by one.
- R4: In split mode, a window count above `ref_count` lowers the affected gain code by one.
- R5: A window count equal to `ref_count` leaves the gain code unchanged.
- R6: The gain codes saturate at 0 and at 63 and never wrap.
- R7: Mode 00 (split): `gain_i` follows the I magnitude count and `gain_q` follows the Q magnitude count, each on its own.
- R8: Mode 01 (locked): both codes are stepped from the I count, starting from `gain_i`, and are equal after each update.
- R9: Mode 10 (direct): both codes take the value of `direct_gain` one clock edge after it is presented.
- R10: Mode 11 (reserved): both codes hold, `direct_gain` is ignored, and `window_done` still pulses at every window close.
- R11: The magnitude bit of the closing strobe counts toward the window that closes. The next window starts from a count of zero.
- R12: The new gain codes become visible in the same cycle in which `window_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | ADC sample strobe; one strobe is one sample |
| i_mag | input | 1 | I-channel magnitude bit, sampled with the strobe |
| q_mag | input | 1 | Q-channel magnitude bit, sampled with the strobe |
| ref_count | input | 10 | Target number of set magnitude bits per window |
| agc_mode | input | 2 | 00 split, 01 locked, 10 direct, 11 reserved |
| direct_gain | input | 6 | Gain word used in direct mode |
| gain_i | output | 6 | I-channel PGA gain code |
| gain_q | output | 6 | Q-channel PGA gain code |
| window_done | output | 1 | One-cycle pulse marking a window evaluation |

## Verification
Two events can fall in the same cycle: the strobe that closes a window, and the magnitude bit that decides whether the count ends one above the reference or equal to it. The bench sets the magnitude bit on the final strobe of a window whose earlier strobes leave the count exactly at the reference. It then judges by the gain direction whether that bit went into the closing window (a step down) or leaked into the next one (no step). A second overlap is a strobe gap in the same stretch as a stale magnitude bit. The gapped window must still close after 512 strobes and not after 512 cycles, and this is checked through the timing of `window_done` and the resulting gains.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT  = 2'b00,
        MODE_LOCK   = 2'b01,
        MODE_DIRECT = 2'b10,
        MODE_RSVD   = 2'b11
    } agc_mode_e;

    typedef enum logic [0:0] {
        ST_ACCUM = 1'b0,
        ST_APPLY = 1'b1
    } agc_state_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/agc_window_counter.sv
module agc_window_counter
    import agc_pkg::*;
#(
    parameter int WIN_LEN = 512,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sample_en,
    input  logic [NUM_CH-1:0]             mag_bits,
    output logic [NUM_CH-1:0][CNT_W-1:0]  win_cnt,
    output logic                          win_close
);

    localparam int SMP_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [SMP_W-1:0] LAST_SMP = SMP_W'(WIN_LEN - 1);

    logic [SMP_W-1:0] smp_cnt;
    logic             last_smp;

    assign last_smp = (smp_cnt == LAST_SMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_cnt   <= '0;
            win_close <= 1'b0;
        end else begin
            win_close <= sample_en && last_smp;
            if (sample_en) begin
                smp_cnt <= last_smp ? '0 : smp_cnt + SMP_W'(1);
            end
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] acc_inc;

        assign acc_inc = acc + CNT_W'(mag_bits[ch]);

        always_ff @(posedge clk) begin
            if (rst) begin
                acc         <= '0;
                win_cnt[ch] <= '0;
            end else if (sample_en) begin
                if (last_smp) begin
                    win_cnt[ch] <= acc_inc;
                    acc         <= '0;
                end else begin
                    acc <= acc_inc;
                end
            end
        end
    end

endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step #(
    parameter int GAIN_W = 6,
    parameter int CNT_W  = 10
) (
    input  logic [GAIN_W-1:0] cur_gain,
    input  logic [CNT_W-1:0]  win_cnt,
    input  logic [CNT_W-1:0]  ref_cnt,
    output logic [GAIN_W-1:0] nxt_gain
);

    localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};
    localparam logic [GAIN_W-1:0] GAIN_MIN = '0;

    always_comb begin
        nxt_gain = cur_gain;
        if (win_cnt < ref_cnt) begin
            if (cur_gain != GAIN_MAX) begin
                nxt_gain = cur_gain + GAIN_W'(1);
            end
        end else if (win_cnt > ref_cnt) begin
            if (cur_gain != GAIN_MIN) begin
                nxt_gain = cur_gain - GAIN_W'(1);
            end
        end
    end

endmodule

// File: rtl/agc_seq_fsm.sv
module agc_seq_fsm
    import agc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       win_close,
    input  logic [1:0] mode,
    output logic       step_en,
    output logic       lock_en,
    output logic       direct_en,
    output logic       window_done
);

    agc_state_e state;
    agc_state_e state_nxt;
    agc_mode_e  mode_e;

    assign mode_e = agc_mode_e'(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ACCUM;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ACCUM: state_nxt = win_close ? ST_APPLY : ST_ACCUM;
            ST_APPLY: state_nxt = ST_ACCUM;
        endcase
    end

    always_comb begin
        step_en     = 1'b0;
        lock_en     = 1'b0;
        direct_en   = 1'b0;
        window_done = (state == ST_APPLY);
        unique case (mode_e)
            MODE_SPLIT: begin
                step_en = (state == ST_ACCUM) && win_close;
            end
            MODE_LOCK: begin
                step_en = (state == ST_ACCUM) && win_close;
                lock_en = 1'b1;
            end
            MODE_DIRECT: begin
                direct_en = 1'b1;
            end
            MODE_RSVD: begin
                step_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mag_agc.sv
module mag_agc
    import agc_pkg::*;
#(
    parameter int WIN_LEN   = 512,
    parameter int GAIN_W    = 6,
    parameter int GAIN_INIT = 58,
    parameter int CNT_W     = $clog2(WIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic              i_mag,
    input  logic              q_mag,
    input  logic [CNT_W-1:0]  ref_count,
    input  logic [1:0]        agc_mode,
    input  logic [GAIN_W-1:0] direct_gain,
    output logic [GAIN_W-1:0] gain_i,
    output logic [GAIN_W-1:0] gain_q,
    output logic              window_done
);

    localparam logic [GAIN_W-1:0] GAIN_RST = GAIN_W'(GAIN_INIT);
    localparam int CH_I = 0;
    localparam int CH_Q = 1;

    logic [NUM_CH-1:0]            mag_bits;
    logic [NUM_CH-1:0][CNT_W-1:0] win_cnt;
    logic                         win_close;
    logic                         step_en;
    logic                         lock_en;
    logic                         direct_en;
    logic [NUM_CH-1:0][GAIN_W-1:0] gain_r;
    logic [NUM_CH-1:0][GAIN_W-1:0] gain_nxt;

    assign mag_bits[CH_I] = i_mag;
    assign mag_bits[CH_Q] = q_mag;

    agc_window_counter #(
        .WIN_LEN (WIN_LEN),
        .CNT_W   (CNT_W)
    ) u_win (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .mag_bits  (mag_bits),
        .win_cnt   (win_cnt),
        .win_close (win_close)
    );

    agc_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .win_close   (win_close),
        .mode        (agc_mode),
        .step_en     (step_en),
        .lock_en     (lock_en),
        .direct_en   (direct_en),
        .window_done (window_done)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_step
        agc_gain_step #(
            .GAIN_W (GAIN_W),
            .CNT_W  (CNT_W)
        ) u_step (
            .cur_gain (gain_r[ch]),
            .win_cnt  (win_cnt[ch]),
            .ref_cnt  (ref_count),
            .nxt_gain (gain_nxt[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_r[CH_I] <= GAIN_RST;
            gain_r[CH_Q] <= GAIN_RST;
        end else if (direct_en) begin
            gain_r[CH_I] <= direct_gain;
            gain_r[CH_Q] <= direct_gain;
        end else if (step_en) begin
            gain_r[CH_I] <= gain_nxt[CH_I];
            gain_r[CH_Q] <= lock_en ? gain_nxt[CH_I] : gain_nxt[CH_Q];
        end
    end

    assign gain_i = gain_r[CH_I];
    assign gain_q = gain_r[CH_Q];

endmodule

// File: rtl/mag_agc_chk.sv
module mag_agc_chk #(
    parameter int GAIN_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        agc_mode,
    input logic [GAIN_W-1:0] direct_gain,
    input logic [GAIN_W-1:0] gain_i,
    input logic [GAIN_W-1:0] gain_q,
    input logic              window_done
);

    localparam logic [GAIN_W-1:0] GMAX = {GAIN_W{1'b1}};

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        window_done |=> !window_done);

    // R9
    direct_load_chk: assert property (@(posedge clk) disable iff (rst)
        (agc_mode == 2'b10) |=> (gain_i == $past(direct_gain)) && (gain_q == $past(direct_gain)));

    // R10
    reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (agc_mode == 2'b11) |=> $stable(gain_i) && $stable(gain_q));

    // R8
    locked_share_chk: assert property (@(posedge clk) disable iff (rst)
        (window_done && $past(agc_mode) == 2'b01) |-> (gain_i == gain_q));

    // R6
    no_wrap_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (agc_mode == 2'b00 && gain_i == GMAX) |=> (gain_i != '0));

    // R6
    no_wrap_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (agc_mode == 2'b00 && gain_q == '0) |=> (gain_q != GMAX));

    // R7
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        (agc_mode == 2'b00) |=>
            ((gain_i == $past(gain_i)) || (gain_i == $past(gain_i) + GAIN_W'(1)) ||
             (gain_i == $past(gain_i) - GAIN_W'(1))) &&
            ((gain_q == $past(gain_q)) || (gain_q == $past(gain_q) + GAIN_W'(1)) ||
             (gain_q == $past(gain_q) - GAIN_W'(1))));

endmodule

bind mag_agc mag_agc_chk #(.GAIN_W(GAIN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .agc_mode    (agc_mode),
    .direct_gain (direct_gain),
    .gain_i      (gain_i),
    .gain_q      (gain_q),
    .window_done (window_done)
);

// File: tb/mag_agc_tb.sv
`timescale 1ns/1ps
module mag_agc_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       sample_en;
    logic       i_mag;
    logic       q_mag;
    logic [9:0] ref_count;
    logic [1:0] agc_mode;
    logic [5:0] direct_gain;
    logic [5:0] gain_i;
    logic [5:0] gain_q;
    logic       window_done;

    int n_chk = 0;
    int n_bad = 0;
    int exp_i = 58;
    int exp_q = 58;
    logic [1:0] cur_mode = 2'b00;

    always #5 clk = ~clk;

    mag_agc u_dut (
        .clk         (clk),
        .rst         (rst),
        .sample_en   (sample_en),
        .i_mag       (i_mag),
        .q_mag       (q_mag),
        .ref_count   (ref_count),
        .agc_mode    (agc_mode),
        .direct_gain (direct_gain),
        .gain_i      (gain_i),
        .gain_q      (gain_q),
        .window_done (window_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_gains(input string req);
        check(int'(gain_i) == exp_i, {req, " gain_i"}, int'(gain_i), exp_i);
        check(int'(gain_q) == exp_q, {req, " gain_q"}, int'(gain_q), exp_q);
    endtask

    function automatic int step_gain(input int g, input int c, input int r);
        if (c < r) return (g == 63) ? 63 : g + 1;
        if (c > r) return (g == 0) ? 0 : g - 1;
        return g;
    endfunction

    task automatic run_window(input int ni, input int nq, input bit last_on,
                              input bit gapped, input string req);
        int ci;
        int cq;
        for (int k = 0; k < 512; k++) begin
            if (gapped && (k % 3 == 1)) begin
                @(negedge clk);
                sample_en = 1'b0;
            end
            @(negedge clk);
            if (k == 511) check(window_done == 1'b0, "R2 no done before last strobe", int'(window_done), 0);
            sample_en = 1'b1;
            i_mag = (k < ni) || (last_on && k == 511);
            q_mag = (k < nq) || (last_on && k == 511);
        end
        @(negedge clk);
        sample_en = 1'b0;
        i_mag = 1'b0;
        q_mag = 1'b0;
        ci = (ni >= 512) ? 512 : ni + (last_on ? 1 : 0);
        cq = (nq >= 512) ? 512 : nq + (last_on ? 1 : 0);
        case (cur_mode)
            2'b00: begin
                exp_i = step_gain(exp_i, ci, int'(ref_count));
                exp_q = step_gain(exp_q, cq, int'(ref_count));
            end
            2'b01: begin
                exp_i = step_gain(exp_i, ci, int'(ref_count));
                exp_q = exp_i;
            end
            default: begin end
        endcase
        @(negedge clk);
        check(window_done == 1'b1, {req, " R2 done pulse"}, int'(window_done), 1);
        // R12: new gains visible together with done
        check_gains({req, " R12"});
        @(negedge clk);
        check(window_done == 1'b0, {req, " R2 single cycle"}, int'(window_done), 0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        agc_mode = m;
        cur_mode = m;
    endtask

    task automatic direct_load(input int g, input string req);
        @(negedge clk);
        agc_mode    = 2'b10;
        cur_mode    = 2'b10;
        direct_gain = 6'(g);
        @(negedge clk);
        exp_i = g;
        exp_q = g;
        check_gains(req);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(int'(gain_i) == 58, "R1 reset gain_i", int'(gain_i), 58);
        check(int'(gain_q) == 58, "R1 reset gain_q", int'(gain_q), 58);
        check(window_done == 1'b0, "R1 reset done", int'(window_done), 0);
        rst = 1'b0;
    endtask

    task automatic test_reserved();
        set_mode(2'b11);
        run_window(0, 512, 1'b0, 1'b0, "R10 reserved window");
        @(negedge clk);
        direct_gain = 6'd40;
        repeat (3) @(negedge clk);
        check_gains("R10 direct ignored");
    endtask

    initial begin
        sample_en   = 1'b0;
        i_mag       = 1'b0;
        q_mag       = 1'b0;
        ref_count   = 10'd170;
        agc_mode    = 2'b00;
        direct_gain = 6'd58;
        test_reset();
        run_window(100, 300, 1'b0, 1'b0, "R3 R4 R7 split");
        run_window(170, 170, 1'b0, 1'b0, "R5 equal");
        run_window(170, 169, 1'b1, 1'b0, "R11 closing strobe");
        run_window(0, 512, 1'b0, 1'b1, "R2 gapped strobes");
        direct_load(63, "R9 direct 63");
        direct_load(5, "R9 direct 5");
        direct_load(63, "R9 direct 63 again");
        set_mode(2'b00);
        run_window(0, 0, 1'b0, 1'b0, "R6 ceiling");
        direct_load(0, "R9 direct 0");
        set_mode(2'b00);
        run_window(512, 512, 1'b0, 1'b0, "R6 floor");
        set_mode(2'b01);
        run_window(0, 512, 1'b0, 1'b0, "R8 locked first");
        run_window(0, 512, 1'b0, 1'b0, "R8 locked second");
        test_reserved();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule